// File: doc/BRIEF.md
# Override-Gated Configuration Output Selector

This block sits between a small configuration register and the pins it controls. A select line routes either an external nibble or the register's low bits onto a multi-bit output bus. The remaining register bit reaches a separate side output through a hold stage. That stage passes the bit straight through while select is low. It freezes it while select is high, so that rewriting the register cannot disturb the side output during that time.

An active-low override input forces both outputs to zero, but only while select is low. While select is high the override is ignored. The hold stage captures whatever the side output was showing, so a forced zero shown just before select rises is the value that gets held. The hold stage is a flop on the system clock. It takes its value at each rising edge where select is low. Reset clears it.

Top module: `cfgmux_gate`

## Requirements
- R1: With select (`sel_i`) at 0 and override (`ovr_ni`) at 1, `mux_o` equals `cfg_i[MUX_W-1:0]` in the same cycle.
- R2: With `sel_i` at 1, `mux_o` equals `ext_i` whatever the value of `ovr_ni`.
- R3: With `sel_i` at 0 and `ovr_ni` at 1, `side_o` equals `cfg_i[MUX_W]` in the same cycle. The hold stage is transparent.
- R4: With `sel_i` at 1, `side_o` shows the value `side_o` had at the last rising clock edge where `sel_i` was 0. Changes on `cfg_i[MUX_W]` while `sel_i` is 1 have no effect on `side_o`.
- R5: With `ovr_ni` at 0 and `sel_i` at 0, `mux_o` is all zeros and `side_o` is 0.
- R6: With `sel_i` at 1, driving `ovr_ni` to 0 changes neither `mux_o` nor `side_o`.
- R7: If a forced zero is shown on `side_o` at the last edge before `sel_i` rises, `side_o` stays 0 while `sel_i` stays 1, even after `ovr_ni` returns to 1 and `cfg_i[MUX_W]` is 1.
- R8: After reset, the hold stage is 0. With `sel_i` at 1 and no edge yet taken with `sel_i` at 0, `side_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the hold stage samples on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | 0: register bits and transparent side path; 1: external nibble and held side value |
| ovr_ni | input | 1 | Override, active low; forces zeros only while `sel_i` is 0 |
| ext_i | input | MUX_W | External data routed to `mux_o` when `sel_i` is 1 |
| cfg_i | input | MUX_W+1 | Configuration register contents; low MUX_W bits feed the bus, the top bit feeds the side path |
| mux_o | output | MUX_W | Selected bus output |
| side_o | output | 1 | Held or transparent side output |

## Verification
The bench builds the block with the default `MUX_W` of 4. At that width the whole input space of the bus path can be reached: every external nibble and every register nibble is swept under both select levels and both override levels. The hold stage gets directed sequences that change `cfg_i` and `ovr_ni` between edges around the select rise. These show which edge the held value comes from. One sequence captures a forced zero and then releases the override.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;
  localparam int unsigned DEF_MUX_W = 4;

  typedef enum logic {
    SRC_CFG = 1'b0,
    SRC_EXT = 1'b1
  } src_e;

  function automatic src_e src_of(input logic sel);
    return sel ? SRC_EXT : SRC_CFG;
  endfunction
endpackage

// File: rtl/cfgmux_path.sv
module cfgmux_path
  import cfgmux_pkg::*;
#(
  parameter int unsigned MUX_W = DEF_MUX_W
) (
  input  logic             sel_i,
  input  logic             ovr_ni,
  input  logic [MUX_W-1:0] ext_i,
  input  logic [MUX_W-1:0] cfg_i,
  output logic [MUX_W-1:0] mux_o
);
  src_e src;
  logic force_zero;

  always_comb begin
    src        = src_of(sel_i);
    force_zero = !sel_i && !ovr_ni;
  end

  for (genvar b = 0; b < MUX_W; b++) begin : g_bit
    logic pick;
    always_comb begin
      pick = (src == SRC_EXT) ? ext_i[b] : cfg_i[b];
      mux_o[b] = force_zero ? 1'b0 : pick;
    end
  end
endmodule

// File: rtl/cfgmux_side_hold.sv
module cfgmux_side_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic ovr_ni,
  input  logic bit_i,
  output logic side_o
);
  logic shown;
  logic hold_q;
  logic past_ok_q;

  // value visible while transparent; override already folded in
  always_comb shown = bit_i && ovr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else if (!sel_i) hold_q <= shown;
  end

  always_comb side_o = sel_i ? hold_q : shown;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else past_ok_q <= 1'b1;
  end

  assert_side_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && sel_i) |-> (side_o == $past(side_o)));

  assert_side_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !ovr_ni) |-> !side_o);

  assert_side_transparent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && ovr_ni) |-> (side_o == bit_i));
endmodule

// File: rtl/cfgmux_gate.sv
module cfgmux_gate
  import cfgmux_pkg::*;
#(
  parameter int unsigned MUX_W = DEF_MUX_W,
  localparam int unsigned CFG_W = MUX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             ovr_ni,
  input  logic [MUX_W-1:0] ext_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [MUX_W-1:0] mux_o,
  output logic             side_o
);
  cfgmux_path #(.MUX_W(MUX_W)) u_path (
    .sel_i (sel_i),
    .ovr_ni(ovr_ni),
    .ext_i (ext_i),
    .cfg_i (cfg_i[MUX_W-1:0]),
    .mux_o (mux_o)
  );

  cfgmux_side_hold u_side (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_i),
    .ovr_ni(ovr_ni),
    .bit_i (cfg_i[MUX_W]),
    .side_o(side_o)
  );

  assert_bus_cfg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && ovr_ni) |-> (mux_o == cfg_i[MUX_W-1:0]));

  assert_bus_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> (mux_o == ext_i));

  assert_bus_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !ovr_ni) |-> (mux_o == '0));
endmodule

// File: tb/cfgmux_gate_bench.sv
module cfgmux_gate_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b1;
  logic         ovr_n = 1'b1;
  logic [W-1:0] ext = '0;
  logic [W:0]   cfg = '0;
  logic [W-1:0] mux;
  logic         side;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfgmux_gate #(.MUX_W(W)) u_cfgmux_gate (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .ovr_ni(ovr_n),
    .ext_i(ext), .cfg_i(cfg), .mux_o(mux), .side_o(side)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset_R8();
    cfg = 5'b1_0000; sel = 1'b1;
    #1;
    chk("R8", {3'b0, side}, 4'h0);
    step(); #1;
    chk("R8", {3'b0, side}, 4'h0);
  endtask

  task automatic t_sweep_R1_R2();
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int e = 0; e < 16; e++)
          for (int c = 0; c < 16; c++) begin
            sel = s[0]; ovr_n = o[0]; ext = e[3:0]; cfg[W-1:0] = c[3:0];
            #1;
            if (s == 1) chk("R2", mux, e[3:0]);
            else if (o == 1) chk("R1", mux, c[3:0]);
            else chk("R5", mux, 4'h0);
          end
    ovr_n = 1'b1;
  endtask

  task automatic t_transparent_R3();
    step(); sel = 1'b0; ovr_n = 1'b1; cfg[W] = 1'b1; #1;
    chk("R3", {3'b0, side}, 4'h1);
    cfg[W] = 1'b0; #1;
    chk("R3", {3'b0, side}, 4'h0);
    cfg[W] = 1'b1; #1;
    chk("R3", {3'b0, side}, 4'h1);
  endtask

  task automatic t_hold_R4();
    step(); sel = 1'b0; ovr_n = 1'b1; cfg[W] = 1'b1;
    step(); sel = 1'b1; cfg[W] = 1'b0; #1;
    chk("R4", {3'b0, side}, 4'h1);
    step(); cfg[W] = 1'b1; step(); cfg[W] = 1'b0; #1;
    chk("R4", {3'b0, side}, 4'h1);
    step(); sel = 1'b0; #1;
    chk("R3", {3'b0, side}, 4'h0);
    step(); sel = 1'b1; cfg[W] = 1'b1; #1;
    chk("R4", {3'b0, side}, 4'h0);
    step(); #1;
    chk("R4", {3'b0, side}, 4'h0);
  endtask

  task automatic t_force_R5();
    step(); sel = 1'b0; ovr_n = 1'b0; cfg = 5'b1_1111; ext = 4'hA; #1;
    chk("R5", mux, 4'h0);
    chk("R5", {3'b0, side}, 4'h0);
    ovr_n = 1'b1; #1;
    chk("R1", mux, 4'hF);
    chk("R3", {3'b0, side}, 4'h1);
  endtask

  task automatic t_ignored_R6();
    step(); sel = 1'b0; ovr_n = 1'b1; cfg = 5'b1_0101;
    step(); sel = 1'b1; ext = 4'h9; #1;
    chk("R6", mux, 4'h9);
    chk("R6", {3'b0, side}, 4'h1);
    ovr_n = 1'b0; #1;
    chk("R6", mux, 4'h9);
    chk("R6", {3'b0, side}, 4'h1);
    step(); step(); #1;
    chk("R6", {3'b0, side}, 4'h1);
    ovr_n = 1'b1;
  endtask

  task automatic t_hold_zero_R7();
    step(); sel = 1'b0; ovr_n = 1'b0; cfg = 5'b1_0011;
    step(); sel = 1'b1; #1;
    chk("R7", {3'b0, side}, 4'h0);
    ovr_n = 1'b1; #1;
    chk("R7", {3'b0, side}, 4'h0);
    step(); step(); #1;
    chk("R7", {3'b0, side}, 4'h0);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step();
    t_reset_R8();
    step(); rst_n = 1'b1;
    t_reset_R8();
    t_sweep_R1_R2();
    t_transparent_R3();
    t_hold_R4();
    t_force_R5();
    t_ignored_R6();
    t_hold_zero_R7();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule